// File: doc/BRIEF.md
# Single-Cycle Self-Loop Liveness Monitor

This block watches a design under check and flags a liveness counterexample of the simplest kind: a state that maps onto itself in one step. It receives the present value of the design's state vector and the value the design has computed for the next cycle. It also receives a save strobe and two groups of property signals. The liveness group holds the conditions that must eventually hold. The fairness group holds the conditions assumed to recur.

When the strobe is high and the next state equals the present state, the design can stay in that state forever. The loop is then a real counterexample if every fairness condition holds in it and at least one liveness condition fails in it. The monitor raises its violation output in exactly that case.

The monitor is purely combinational. It keeps no copy of an earlier state and adds no flip-flop to the design it observes. An empty liveness group counts as always true, and so does an empty fairness group. The corresponding input port then shrinks to one bit, and the monitor ignores that bit.

Top module: `self_loop_monitor`

## Requirements
- R1: The state-match term is true only when every one of the STATE_W bit pairs of `cur_state` and `nxt_state` agree; a difference in any single bit position forces `violation` to 0.
- R2: With `save` at 0, `violation` is 0 whatever the other inputs are.
- R3: With NUM_FAIR > 0, a 0 on any bit of `fair_in` forces `violation` to 0.
- R4: With NUM_LIVE > 0, `live_in` at all ones forces `violation` to 0.
- R5: `violation` is 1 exactly when `save` is 1, the states match, every fairness bit is 1, and at least one liveness bit is 0.
- R6: With NUM_LIVE = 0, the liveness term is constant 1, so `violation` stays 0; the one-bit `live_in` has no effect.
- R7: With NUM_FAIR = 0, the fairness term is constant 1; the one-bit `fair_in` has no effect on `violation`.
- R8: The block holds no state: `violation` reflects the inputs present in the same cycle, with no dependence on earlier cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_state | input | STATE_W | Present state of the observed design |
| nxt_state | input | STATE_W | Next-state value computed by the observed design |
| save | input | 1 | Marks the present cycle as the candidate loop point |
| live_in | input | max(NUM_LIVE,1) | Liveness conditions, one bit each (ignored when NUM_LIVE = 0) |
| fair_in | input | max(NUM_FAIR,1) | Fairness conditions, one bit each (ignored when NUM_FAIR = 0) |
| violation | output | 1 | High when a fair self-loop that misses liveness is present |

## Verification
The bench builds three instances side by side. The first uses STATE_W=8, NUM_LIVE=3 and NUM_FAIR=2, which exercises the full gating. The second uses STATE_W=4 with both property groups empty, where the output must never rise. The third uses STATE_W=3, NUM_LIVE=2 and NUM_FAIR=0, where the fairness port must be inert. Directed patterns flip each state bit on its own, drop each fairness bit on its own and raise all liveness bits at once. A random phase follows that biases the next state towards equality, so matching loops are common. Each instance is compared every cycle with a behavioural model. The inputs change every cycle, so any dependence on an earlier cycle shows up as a mismatch.

// File: rtl/lsm_pkg.sv
// Package: shared helpers for the self-loop liveness monitor.
// Assumes: callers pass non-negative counts.
package lsm_pkg;

    // Port width for a group that may be empty: never below one bit.
    function automatic int port_w(input int n);
        return (n > 0) ? n : 1;
    endfunction

endpackage

// File: rtl/lsm_state_match.sv
// Module: lsm_state_match
// Purpose: reports whether two state vectors agree on every bit, built as a
//          chain of per-bit XNOR terms folded with AND.
// Assumes: WIDTH >= 1.
module lsm_state_match #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_vec,
    input  logic [WIDTH-1:0] b_vec,
    output logic             same
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b1;

    // One XNOR-and-AND stage per state bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign chain[i+1] = chain[i] & ~(a_vec[i] ^ b_vec[i]);
    end

    assign same = chain[WIDTH];

    // Guard: a claimed match must mean the vectors are equal as whole words (R1).
    always_comb begin
        p_match_exact_r1: assert (!same || (a_vec == b_vec));
    end

endmodule

// File: rtl/lsm_all_true.sv
// Module: lsm_all_true
// Purpose: ANDs a group of property bits; an empty group yields constant 1.
// Assumes: COUNT >= 0; with COUNT = 0 the single input bit is ignored.
module lsm_all_true
    import lsm_pkg::*;
#(
    parameter int COUNT = 2,
    localparam int PW   = port_w(COUNT)
) (
    input  logic [PW-1:0] bits,
    output logic          all_set
);

    if (COUNT == 0) begin : g_empty
        logic unused_bits;
        // Empty group: term is the identity of AND.
        assign unused_bits = ^bits;
        assign all_set     = 1'b1;
    end else begin : g_group
        logic [COUNT:0] acc;
        assign acc[0] = 1'b1;
        // One AND stage per property bit.
        for (genvar i = 0; i < COUNT; i++) begin : g_stage
            assign acc[i+1] = acc[i] & bits[i];
        end
        assign all_set = acc[COUNT];

        // Guard: a true result needs no zero among the used bits (R3, R4).
        always_comb begin
            p_group_all_ones_r3: assert (!all_set || (bits[COUNT-1:0] == {COUNT{1'b1}}));
        end
    end

endmodule

// File: rtl/self_loop_monitor.sv
// Module: self_loop_monitor (top)
// Purpose: flags a self-loop of length one in which every fairness condition
//          holds and some liveness condition fails.
// Assumes: STATE_W >= 1; NUM_LIVE and NUM_FAIR may be 0. Purely combinational:
//          no clock, no reset, no storage.
module self_loop_monitor
    import lsm_pkg::*;
#(
    parameter int STATE_W  = 8,
    parameter int NUM_LIVE = 3,
    parameter int NUM_FAIR = 2,
    localparam int LW      = port_w(NUM_LIVE),
    localparam int FW      = port_w(NUM_FAIR)
) (
    input  logic [STATE_W-1:0] cur_state,
    input  logic [STATE_W-1:0] nxt_state,
    input  logic               save,
    input  logic [LW-1:0]      live_in,
    input  logic [FW-1:0]      fair_in,
    output logic               violation
);

    logic states_equal;
    logic loop_closed;
    logic live_ok;
    logic fair_ok;

    lsm_state_match #(.WIDTH(STATE_W)) u_match (
        .a_vec (cur_state),
        .b_vec (nxt_state),
        .same  (states_equal)
    );

    lsm_all_true #(.COUNT(NUM_LIVE)) u_live (
        .bits    (live_in),
        .all_set (live_ok)
    );

    lsm_all_true #(.COUNT(NUM_FAIR)) u_fair (
        .bits    (fair_in),
        .all_set (fair_ok)
    );

    // Loop point: strobe taken while the state maps onto itself.
    assign loop_closed = save & states_equal;

    // Counterexample: fair loop in which liveness is not met.
    assign violation = loop_closed & fair_ok & ~live_ok;

    // Port-level guards relating the output to the raw inputs.
    always_comb begin
        p_no_flag_without_save_r2: assert (!violation || save);
        p_no_flag_on_mismatch_r1:  assert (!violation || (cur_state == nxt_state));
        if (NUM_LIVE == 0) begin
            p_empty_live_silent_r6: assert (!violation);
        end
        if (NUM_LIVE > 0) begin
            p_full_live_silent_r4: assert (!(violation && (&live_in)));
        end
        if (NUM_FAIR > 0) begin
            p_fair_needed_r3: assert (!violation || (&fair_in));
        end
    end

endmodule

// File: tb/self_loop_monitor_tb_top.sv
// Bench: three monitor instances compared each cycle against a behavioural model.
module self_loop_monitor_tb_top;

    localparam int K_A = 8, L_A = 3, F_A = 2;
    localparam int K_B = 4;
    localparam int K_C = 3, L_C = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_checks = 0;
    int n_fail   = 0;

    // Instance A: full gating.
    logic [K_A-1:0] a_cur, a_nxt;
    logic           a_save;
    logic [L_A-1:0] a_live;
    logic [F_A-1:0] a_fair;
    logic           a_viol;

    self_loop_monitor #(.STATE_W(K_A), .NUM_LIVE(L_A), .NUM_FAIR(F_A)) dut_i (
        .cur_state(a_cur), .nxt_state(a_nxt), .save(a_save),
        .live_in(a_live), .fair_in(a_fair), .violation(a_viol));

    // Instance B: both groups empty.
    logic [K_B-1:0] b_cur, b_nxt;
    logic           b_save, b_live, b_fair, b_viol;

    self_loop_monitor #(.STATE_W(K_B), .NUM_LIVE(0), .NUM_FAIR(0)) dut_b (
        .cur_state(b_cur), .nxt_state(b_nxt), .save(b_save),
        .live_in(b_live), .fair_in(b_fair), .violation(b_viol));

    // Instance C: no fairness conditions.
    logic [K_C-1:0] c_cur, c_nxt;
    logic           c_save, c_fair, c_viol;
    logic [L_C-1:0] c_live;

    self_loop_monitor #(.STATE_W(K_C), .NUM_LIVE(L_C), .NUM_FAIR(0)) dut_c (
        .cur_state(c_cur), .nxt_state(c_nxt), .save(c_save),
        .live_in(c_live), .fair_in(c_fair), .violation(c_viol));

    // Behavioural reference: loops over bits, empty groups count as true.
    function automatic bit model(input bit sv, input int k, input logic [31:0] cs,
                                 input logic [31:0] ns, input int nl, input logic [31:0] lv,
                                 input int nf, input logic [31:0] fv);
        bit eq = 1, la = 1, fa = 1;
        for (int i = 0; i < k; i++) if (cs[i] != ns[i]) eq = 0;
        for (int i = 0; i < nl; i++) if (!lv[i]) la = 0;
        for (int i = 0; i < nf; i++) if (!fv[i]) fa = 0;
        return sv && eq && fa && !la;
    endfunction

    task automatic check(input string req, input logic got, input bit exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: violation=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    // Compare all three instances with the model (called away from the clock edge).
    task automatic compare_all(input string req);
        check({req, " A"}, a_viol, model(a_save, K_A, 32'(a_cur), 32'(a_nxt), L_A, 32'(a_live), F_A, 32'(a_fair)));
        check({req, " B (R6)"}, b_viol, model(b_save, K_B, 32'(b_cur), 32'(b_nxt), 0, 32'(b_live), 0, 32'(b_fair)));
        check({req, " C (R7)"}, c_viol, model(c_save, K_C, 32'(c_cur), 32'(c_nxt), L_C, 32'(c_live), 0, 32'(c_fair)));
    endtask

    // Apply a vector to A at the falling edge, check it after the next rising edge.
    task automatic step_a(input logic [K_A-1:0] cs, input logic [K_A-1:0] ns, input logic sv,
                          input logic [L_A-1:0] lv, input logic [F_A-1:0] fv,
                          input bit exp, input string req);
        @(negedge clk);
        a_cur = cs; a_nxt = ns; a_save = sv; a_live = lv; a_fair = fv;
        @(posedge clk); #1;
        check(req, a_viol, exp);
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        a_cur = '0; a_nxt = '0; a_save = 0; a_live = '0; a_fair = '0;
        b_cur = '0; b_nxt = '0; b_save = 0; b_live = 0;  b_fair = 0;
        c_cur = '0; c_nxt = '0; c_save = 0; c_live = '0; c_fair = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state: no strobe, nothing flagged (R2).
        check("R2 idle A", a_viol, 1'b0);
        check("R2 idle B", b_viol, 1'b0);
        check("R2 idle C", c_viol, 1'b0);

        // Main positive case (R5).
        step_a(8'h5A, 8'h5A, 1, 3'b010, 2'b11, 1, "R5 fair loop live missing");
        step_a(8'h00, 8'h00, 1, 3'b000, 2'b11, 1, "R5 all live low");
        // Strobe low (R2).
        step_a(8'h5A, 8'h5A, 0, 3'b010, 2'b11, 0, "R2 save low");
        // Same inputs back-to-back and after a change: no memory (R8).
        step_a(8'hC3, 8'hC3, 1, 3'b110, 2'b11, 1, "R8 first");
        step_a(8'hC3, 8'hC3, 0, 3'b110, 2'b11, 0, "R8 strobe removed");
        step_a(8'hC3, 8'hC3, 1, 3'b110, 2'b11, 1, "R8 strobe back");
        // Each single-bit mismatch (R1).
        for (int i = 0; i < K_A; i++) begin
            step_a(8'hA5, 8'hA5 ^ (8'h01 << i), 1, 3'b000, 2'b11, 0, $sformatf("R1 bit %0d differs", i));
        end
        // Each fairness bit dropped (R3).
        for (int i = 0; i < F_A; i++) begin
            step_a(8'h3C, 8'h3C, 1, 3'b001, 2'b11 ^ (2'b01 << i), 0, $sformatf("R3 fair bit %0d low", i));
        end
        // All liveness high (R4).
        step_a(8'h3C, 8'h3C, 1, 3'b111, 2'b11, 0, "R4 live all ones");

        // Empty liveness group never flags, whatever live_in holds (R6).
        @(negedge clk);
        b_cur = 4'h9; b_nxt = 4'h9; b_save = 1; b_live = 0; b_fair = 0;
        @(posedge clk); #1;
        check("R6 empty live, bit 0", b_viol, 1'b0);
        @(negedge clk);
        b_live = 1; b_fair = 1;
        @(posedge clk); #1;
        check("R6 empty live, bit 1", b_viol, 1'b0);

        // Empty fairness group: fair_in has no effect (R7).
        @(negedge clk);
        c_cur = 3'b101; c_nxt = 3'b101; c_save = 1; c_live = 2'b01; c_fair = 0;
        @(posedge clk); #1;
        check("R7 fair_in=0 ignored", c_viol, 1'b1);
        @(negedge clk);
        c_fair = 1;
        @(posedge clk); #1;
        check("R7 fair_in=1 ignored", c_viol, 1'b1);

        // Random phase, biased towards matching states (R5, R8).
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            a_cur = 8'($urandom); b_cur = 4'($urandom); c_cur = 3'($urandom);
            a_nxt = a_cur; b_nxt = b_cur; c_nxt = c_cur;
            if ($urandom_range(0, 1) == 1) begin
                a_nxt = a_cur ^ (8'h01 << $urandom_range(0, K_A - 1));
                b_nxt = 4'($urandom);
                c_nxt = 3'($urandom);
            end
            a_save = 1'($urandom); b_save = 1'($urandom); c_save = 1'($urandom);
            a_live = 3'($urandom); b_live = 1'($urandom); c_live = 2'($urandom);
            a_fair = ($urandom_range(0, 3) != 0) ? 2'b11 : 2'($urandom);
            b_fair = 1'($urandom); c_fair = 1'($urandom);
            @(posedge clk); #1;
            compare_all("R5 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule